// File: doc/BRIEF.md
# Serial memory page write controller

This block sits behind a two-wire serial memory's protocol engine and handles writes to the storage array. During a write transfer the engine first loads a word address, then hands over each data byte it has fully received. The block keeps those bytes in a 32-entry page buffer and marks each filled entry in a valid mask. Each accepted byte advances the word-address pointer, and the pointer stays inside the current 32-byte page.

When the stop condition ends the transfer, the block copies only the marked bytes into the array in a single step. It then raises a busy flag for a programmable number of clock cycles. While the flag is high the block ignores every request from the engine, so the engine can answer polling requests with no acknowledge until the flag falls.

A write-protect level blocks data bytes from entering the buffer, and with it any commit. A separate registered read port gives the engine access to the array for its read transfers. The array is a register file whose size is a parameter.

Top module: `eep_page_writer`

## Requirements
- R1: After reset `busy_o` is 0, `ptr_o` is 0 and `byte_take_o` is 0.
- R2: When idle (not busy), a cycle with `addr_load_i` high loads `ptr_o` with `addr_i` on the following clock edge, and clears the page buffer's valid mask.
- R3: A data byte presented with `data_vld_i` while idle, write-protect low, and no load or stop in the same cycle, is accepted. `byte_take_o` is high in that cycle. At the next edge the low five pointer bits increment modulo 32 and the upper pointer bits stay unchanged.
- R4: When more than 32 bytes arrive in one transfer, a later byte that lands on an already filled page offset replaces the earlier byte. The array receives only the last byte written to each offset.
- R5: At commit, only page offsets that received a byte in the current transfer are written. The other locations of the page keep their old contents.
- R6: The array does not change before the stop. A read of a buffered address ahead of the stop returns the old contents.
- R7: A stop accepted while idle, with at least one byte buffered and write-protect low, raises `busy_o` from the next edge. `busy_o` then stays high for exactly WR_CYCLES clock cycles.
- R8: While `busy_o` is high, `addr_load_i`, `data_vld_i` and `stop_i` have no effect. `ptr_o` holds, `byte_take_o` stays 0, and the busy period is not extended.
- R9: While `wp_i` is high, data bytes are not taken and do not move the pointer. A stop with `wp_i` high starts no busy period and leaves the array unchanged.
- R10: A stop that follows an address load with no accepted data byte starts no busy period and leaves `ptr_o` at the loaded address.
- R11: `rd_data_o` shows the array byte at `rd_addr_i` one clock edge after the address is presented. After `busy_o` falls, it returns the committed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write-protect level, high blocks writes |
| addr_load_i | input | 1 | Load word address into the pointer |
| addr_i | input | ADDR_W | Word address to load |
| data_vld_i | input | 1 | A complete data byte is offered |
| data_i | input | 8 | Offered data byte |
| stop_i | input | 1 | Stop condition ends the transfer |
| rd_addr_i | input | ADDR_W | Read port address |
| busy_o | output | 1 | Internal write cycle in progress |
| byte_take_o | output | 1 | Offered byte accepted this cycle |
| ptr_o | output | ADDR_W | Word-address pointer |
| rd_data_o | output | 8 | Read port data, one cycle latency |

## Verification
The commit path is exercised with four transfer shapes:
- A full 32-byte page from offset zero shows that every offset lands at its own address.
- A three-byte transfer into the middle of that page separates masked writing from a whole-page copy, because the neighbouring bytes must survive.
- A 34-byte transfer that starts two bytes before the page end shows in-page wrap and overwrite order, and separates it from a carry into the next page.
- Transfers under write-protect, transfers that carry only an address, and requests issued during the busy window each tell "ignored" apart from "acted on", by the pointer value, the busy length and the array contents read back afterwards.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int PAGE_BYTES = 32;
  localparam int OFS_W      = $clog2(PAGE_BYTES);
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgc_ptr.sv
module pgc_ptr
  import pgc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step_en,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [OFS_W-1:0]  ofs_inc;

  assign ofs_inc = ptr_q[OFS_W-1:0] + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en)      ptr_d = load_addr;
    else if (step_en) ptr_d = {ptr_q[ADDR_W-1:OFS_W], ofs_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (load_en || step_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/pgc_pagebuf.sv
module pgc_pagebuf
  import pgc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_en,
  input  logic                  wr_en,
  input  logic [OFS_W-1:0]      wr_ofs,
  input  byte_t                 wr_data,
  output byte_t                 pbuf [PAGE_BYTES],
  output logic [PAGE_BYTES-1:0] mask
);
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [PAGE_BYTES-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < PAGE_BYTES; g++) begin : g_ent
      byte_t data_q;
      assign hit[g] = wr_en && (wr_ofs == OFS_W'(g));
      always_ff @(posedge clk) begin
        if (hit[g]) data_q <= wr_data;
      end
      assign pbuf[g] = data_q;
    end
  endgenerate

  always_comb begin
    mask_d = mask_q;
    if (clr_en)     mask_d = '0;
    else if (wr_en) mask_d = mask_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (clr_en || wr_en) mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
  parameter int WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WR_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q || start) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/pgc_array.sv
module pgc_array
  import pgc_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_en,
  input  logic [ADDR_W-OFS_W-1:0]  page_sel,
  input  byte_t                    pbuf [PAGE_BYTES],
  input  logic [PAGE_BYTES-1:0]    mask,
  input  logic [ADDR_W-1:0]        rd_addr,
  output byte_t                    rd_data
);
  byte_t mem [MEM_BYTES];
  byte_t rd_q;

  always_ff @(posedge clk) begin
    if (commit_en) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask[i]) mem[{page_sel, OFS_W'(i)}] <= pbuf[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import pgc_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter int WR_CYCLES = 500000,
  parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              busy_o,
  output logic              byte_take_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [7:0]        rd_data_o
);
  logic                  idle;
  logic                  load_en, take_en, stop_en, commit_en;
  logic [ADDR_W-1:0]     ptr;
  byte_t                 pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic                  busy;

  assign idle      = !busy;
  assign load_en   = idle && addr_load_i;
  assign stop_en   = idle && stop_i;
  assign take_en   = idle && data_vld_i && !wp_i && !addr_load_i && !stop_i;
  assign commit_en = stop_en && !wp_i && (|mask);

  pgc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_addr(addr_i),
    .step_en  (take_en),
    .ptr      (ptr)
  );

  pgc_pagebuf u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (load_en || stop_en),
    .wr_en  (take_en),
    .wr_ofs (ptr[OFS_W-1:0]),
    .wr_data(data_i),
    .pbuf   (pbuf),
    .mask   (mask)
  );

  pgc_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(commit_en),
    .busy (busy)
  );

  pgc_array #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_en(commit_en),
    .page_sel (ptr[ADDR_W-1:OFS_W]),
    .pbuf     (pbuf),
    .mask     (mask),
    .rd_addr  (rd_addr_i),
    .rd_data  (rd_data_o)
  );

  assign busy_o      = busy;
  assign byte_take_o = take_en;
  assign ptr_o       = ptr;
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk
  import pgc_pkg::*;
#(
  parameter int WR_CYCLES = 500000,
  parameter int ADDR_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_i,
  input logic              stop_i,
  input logic              busy_o,
  input logic              byte_take_o,
  input logic [ADDR_W-1:0] ptr_o
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_len < 32'(WR_CYCLES)));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len == 32'(WR_CYCLES)));

  // R8
  busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(ptr_o));

  // R8
  busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !byte_take_o);

  // R3
  take_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take_o |=> (ptr_o[ADDR_W-1:OFS_W] == $past(ptr_o[ADDR_W-1:OFS_W])) &&
                    (ptr_o[OFS_W-1:0] == OFS_W'($past(ptr_o[OFS_W-1:0]) + 1'b1)));

  // R9
  wp_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  // R7
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));
endmodule

bind eep_page_writer eep_page_writer_chk #(
  .WR_CYCLES(WR_CYCLES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_i       (wp_i),
  .stop_i     (stop_i),
  .busy_o     (busy_o),
  .byte_take_o(byte_take_o),
  .ptr_o      (ptr_o)
);

// File: tb/eep_page_writer_bench.sv
module eep_page_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 4096;
  localparam int WR_CYCLES  = 24;
  localparam int ADDR_W     = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wp_i = 1'b0;
  logic              addr_load_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              data_vld_i = 1'b0;
  logic [7:0]        data_i = '0;
  logic              stop_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic              busy_o, byte_take_o;
  logic [ADDR_W-1:0] ptr_o;
  logic [7:0]        rd_data_o;

  int errors = 0;
  int checks = 0;

  typedef struct { logic [7:0] exp; logic [ADDR_W-1:0] addr; string req; } rd_item_t;
  rd_item_t   sb_q [$];
  logic       rd_req = 1'b0;
  logic [7:0] model [int];

  eep_page_writer #(.MEM_BYTES(MEM_BYTES), .WR_CYCLES(WR_CYCLES)) u_eep_page_writer (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .data_vld_i(data_vld_i), .data_i(data_i), .stop_i(stop_i), .rd_addr_i(rd_addr_i),
    .busy_o(busy_o), .byte_take_o(byte_take_o), .ptr_o(ptr_o), .rd_data_o(rd_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares read data one edge after a request
  always @(posedge clk) begin
    automatic bit take = rd_req;
    #(CLK_PERIOD/4);
    if (take) begin
      rd_item_t it;
      it = sb_q.pop_front();
      chk(rd_data_o === it.exp, it.req, {20'h0, rd_data_o}, {20'h0, it.exp});
    end
  end

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input string req);
    rd_item_t it;
    it.exp = model[int'(a)]; it.addr = a; it.req = req;
    sb_q.push_back(it);
    rd_addr_i = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic load(input logic [ADDR_W-1:0] a);
    addr_load_i = 1'b1; addr_i = a;
    @(negedge clk);
    addr_load_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit exp_take, input string req);
    data_vld_i = 1'b1; data_i = d;
    #1;
    chk(byte_take_o === exp_take, req, {31'h0, byte_take_o}, {31'h0, exp_take});
    @(negedge clk);
    data_vld_i = 1'b0;
  endtask

  task automatic stop_measure(output int n);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    n = 0;
    while (busy_o === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_page(input logic [ADDR_W-1:0] base, input string req);
    for (int i = 0; i < 32; i++) rd_chk(base + ADDR_W'(i), req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [ADDR_W-1:0] p;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o === 1'b0, "R1 busy", {31'h0, busy_o}, 0);
    chk(ptr_o === '0, "R1 ptr", {20'h0, ptr_o}, 0);
    chk(byte_take_o === 1'b0, "R1 take", {31'h0, byte_take_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full page at 0x120; R7 busy length, R11 readback
    load(12'h120);
    for (int i = 0; i < 32; i++) begin
      send(8'h40 + 8'(i), 1'b1, "R3 take");
      model[32'h120 + i] = 8'h40 + 8'(i);
    end
    chk(ptr_o === 12'h120, "R3 full-page wrap", {20'h0, ptr_o}, 32'h120);
    stop_measure(n);
    chk(n == WR_CYCLES, "R7 busy cycles", n, WR_CYCLES);
    read_page(12'h120, "R11 readback");

    // Partial write in mid page: R2, R3, R6, R5
    load(12'h123);
    chk(ptr_o === 12'h123, "R2 load", {20'h0, ptr_o}, 32'h123);
    for (int i = 0; i < 3; i++) begin
      send(8'hC0 + 8'(i), 1'b1, "R3 take");
      chk(ptr_o === 12'h124 + ADDR_W'(i), "R3 step", {20'h0, ptr_o}, 32'h124 + i);
    end
    rd_chk(12'h123, "R6 pre-stop old");
    for (int i = 0; i < 3; i++) model[32'h123 + i] = 8'hC0 + 8'(i);
    stop_measure(n);
    chk(n == WR_CYCLES, "R7 busy cycles", n, WR_CYCLES);
    read_page(12'h120, "R5 partial");

    // 34 bytes from offset 30: R3 wrap, R4 overwrite
    load(12'h13E);
    for (int i = 0; i < 34; i++) begin
      send(8'h80 + 8'(i), 1'b1, "R4 take");
      p = 12'h120 + ADDR_W'((30 + i) % 32);
      model[int'(p)] = 8'h80 + 8'(i);
    end
    chk(ptr_o === 12'h120, "R3 in-page wrap", {20'h0, ptr_o}, 32'h120);
    stop_measure(n);
    read_page(12'h120, "R4 overwrite");
    rd_chk(12'h140, "R4 next page untouched");

    // R8 requests during busy are ignored
    model[32'h140] = 8'h11;
    load(12'h140);
    send(8'h11, 1'b1, "R8 setup");
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    n = 1;
    addr_load_i = 1'b1; addr_i = 12'h300;
    @(negedge clk); n++;
    addr_load_i = 1'b0;
    chk(ptr_o === 12'h141, "R8 load ignored", {20'h0, ptr_o}, 32'h141);
    data_vld_i = 1'b1; data_i = 8'h77;
    #1;
    chk(byte_take_o === 1'b0, "R8 byte ignored", {31'h0, byte_take_o}, 0);
    @(negedge clk); n++;
    data_vld_i = 1'b0;
    stop_i = 1'b1;
    @(negedge clk); n++;
    stop_i = 1'b0;
    while (busy_o === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n - 1 == WR_CYCLES, "R8 busy not extended", n - 1, WR_CYCLES);
    chk(ptr_o === 12'h141, "R8 ptr held", {20'h0, ptr_o}, 32'h141);
    rd_chk(12'h140, "R8 data");
    rd_chk(12'h141, "R8 stray byte not written");

    // R9 write protect
    load(12'h140);
    wp_i = 1'b1;
    send(8'h99, 1'b0, "R9 byte refused");
    chk(ptr_o === 12'h140, "R9 ptr held", {20'h0, ptr_o}, 32'h140);
    stop_measure(n);
    chk(n == 0, "R9 no busy", n, 0);
    wp_i = 1'b0;
    rd_chk(12'h140, "R9 array unchanged");

    // R10 address-only transfer
    load(12'h345);
    stop_measure(n);
    chk(n == 0, "R10 no busy", n, 0);
    chk(ptr_o === 12'h345, "R10 ptr", {20'h0, ptr_o}, 32'h345);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R11 scoreboard drained", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule